// File: doc/BRIEF.md
# Prescaled Real-Time Tick Counter

This block keeps elapsed time for a chip. A slow reference (nominally 32768 Hz) arrives as a one-cycle enable pulse in the fast system clock domain. A 16-bit programmable prescaler divides that pulse down. Each time the prescaler wraps, a 32-bit value counter steps by one and an increment status flag is raised. An alarm register is compared against the counter. The alarm flag rises on the step that takes the counter one past the stored alarm value. An alarm register of all ones turns alarm detection off.

Software reaches four 32-bit registers over a simple single-cycle read/write bus. Read data is combinational from the address. Two interrupt enables in the mode register gate the two flags onto one level-sensitive interrupt line. Reading the status register clears both flags, and with them the interrupt. A write to the mode register with the restart bit set zeroes the counter and the prescaler, which gives a clean start for a new measurement.

Top module: `rt_tick_timer`

## Requirements
- R1: After reset the mode register reads 0x0000_8000, the alarm register reads 0xFFFF_FFFF, and value and status both read 0. The interrupt output is low.
- R2: Only address bits 3:2 select a register: 0 is mode, 1 is alarm, 2 is value and 3 is status. All other address bits are ignored. The alarm register is read/write.
- R3: With mode bits 15:0 equal to a non-zero N, the value counter steps by one on every N-th reference pulse. Without reference pulses the counter holds.
- R4: With mode bits 15:0 equal to zero, the counter steps once every 32768 reference pulses.
- R5: A mode write with bit 18 set clears the value counter and restarts the prescaler count. Bit 18 always reads back as 0.
- R6: Status bit 1 (the increment flag) is set on every counter step.
- R7: Status bit 0 (the alarm flag) is set on the step that moves the counter from the alarm value to the alarm value plus one. It is never set while the alarm register holds all ones.
- R8: The interrupt output is high exactly when (status bit 1 and mode bit 17) or (status bit 0 and mode bit 16) are both set.
- R9: A status read clears both flags, and the interrupt is low in the next cycle. A flag event in the same cycle as the read wins, and that flag stays set.
- R10: Writes to the value and status registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | One-cycle enable pulse per reference period |
| busAddr | input | 12 | Byte address of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe; a status read clears the flags |
| busRdData | output | 32 | Combinational read data for busAddr |
| irqOut | output | 1 | Level interrupt |

## Verification
The assertions assume that `refTick` is a clean one-cycle-wide enable. They also assume that a bus access lasts one cycle, with at most one of read or write asserted at a time, and that the address is stable while a strobe is high. The bench drives every input just after a rising edge and holds it for one full cycle. It never raises both bus strobes together. It overlaps a reference pulse with a status read only in the single cycle built to test read-versus-event priority. Prescaler settings are kept small so that counter steps occur at predictable cycles. The full 32768 divide is exercised once.

// File: rtl/rt_tick_timer_pkg.sv
package rt_tick_timer_pkg;

  localparam int DATA_W = 32;
  localparam int PRE_W  = 16;

  // register select from address bits 3:2
  localparam logic [1:0] SEL_MODE   = 2'd0;
  localparam logic [1:0] SEL_ALARM  = 2'd1;
  localparam logic [1:0] SEL_VALUE  = 2'd2;
  localparam logic [1:0] SEL_STATUS = 2'd3;

  // mode register bit positions
  localparam int BIT_ALM_IEN = 16;
  localparam int BIT_INC_IEN = 17;
  localparam int BIT_RESTART = 18;

  // status flag positions
  localparam int NUM_FLAGS = 2;
  localparam int ST_ALM    = 0;
  localparam int ST_INC    = 1;

  typedef struct packed {
    logic restart;
    logic clrStatus;
  } ctlStrobe_t;

  typedef struct packed {
    logic inc;
    logic alarm;
  } cntEvent_t;

endpackage

// File: rtl/rt_tick_datapath.sv
module rt_tick_datapath
  import rt_tick_timer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DIV_W    = 16,
  parameter int FULL_DIV = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  ctlStrobe_t       strobe,
  input  logic [DIV_W-1:0] modeDiv,
  input  logic [CNT_W-1:0] alarmVal,
  output logic [CNT_W-1:0] valueCnt,
  output cntEvent_t        evt
);

  localparam int EXT_W = DIV_W + 1;

  logic [DIV_W-1:0] preCnt;
  logic [EXT_W-1:0] preNext;
  logic [EXT_W-1:0] divEff;
  logic             preWrap;
  logic             advance;
  logic             alarmArmed;

  // zero divide field selects the full-second divide
  assign divEff  = (modeDiv == '0) ? EXT_W'(FULL_DIV) : {1'b0, modeDiv};
  assign preNext = {1'b0, preCnt} + EXT_W'(1);
  // >= keeps the count bounded when the divisor shrinks mid-period
  assign preWrap = (preNext >= divEff);
  assign advance = refTick && preWrap && !strobe.restart;

  assign alarmArmed = (alarmVal != '1);
  assign evt.inc    = advance;
  assign evt.alarm  = advance && alarmArmed && (valueCnt == alarmVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      valueCnt <= '0;
    end else if (strobe.restart) begin
      preCnt   <= '0;
      valueCnt <= '0;
    end else if (refTick) begin
      if (preWrap) begin
        preCnt   <= '0;
        valueCnt <= valueCnt + CNT_W'(1);
      end else begin
        preCnt <= preCnt + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/rt_tick_ctrl.sv
module rt_tick_ctrl
  import rt_tick_timer_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CNT_W     = 32,
  parameter int DIV_W     = 16,
  parameter int RESET_DIV = 32768
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [CNT_W-1:0]     busWrData,
  input  logic                 busRdEn,
  output logic [CNT_W-1:0]     busRdData,
  output logic                 irqOut,
  input  cntEvent_t            evt,
  input  logic [CNT_W-1:0]     valueCnt,
  output ctlStrobe_t           strobe,
  output logic [DIV_W-1:0]     modeDiv,
  output logic [CNT_W-1:0]     alarmVal,
  output logic [NUM_FLAGS-1:0] flagVec
);

  logic [1:0]           regSel;
  logic                 wrMode;
  logic                 wrAlarm;
  logic                 almIen;
  logic                 incIen;
  logic [NUM_FLAGS-1:0] evtVec;
  logic [NUM_FLAGS-1:0] ienVec;
  logic [CNT_W-1:0]     modeRead;
  logic [CNT_W-1:0]     statusRead;
  logic                 unusedAddr;

  assign regSel     = busAddr[3:2];
  assign unusedAddr = ^{busAddr[ADDR_W-1:4], busAddr[1:0]};

  assign wrMode           = busWrEn && (regSel == SEL_MODE);
  assign wrAlarm          = busWrEn && (regSel == SEL_ALARM);
  assign strobe.restart   = wrMode && busWrData[BIT_RESTART];
  assign strobe.clrStatus = busRdEn && (regSel == SEL_STATUS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeDiv <= DIV_W'(RESET_DIV);
      almIen  <= 1'b0;
      incIen  <= 1'b0;
    end else if (wrMode) begin
      modeDiv <= busWrData[DIV_W-1:0];
      almIen  <= busWrData[BIT_ALM_IEN];
      incIen  <= busWrData[BIT_INC_IEN];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmVal <= '1;
    end else if (wrAlarm) begin
      alarmVal <= busWrData;
    end
  end

  assign evtVec[ST_ALM] = evt.alarm;
  assign evtVec[ST_INC] = evt.inc;
  assign ienVec[ST_ALM] = almIen;
  assign ienVec[ST_INC] = incIen;

  // a new event outranks the read-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagVec <= '0;
    end else begin
      for (int i = 0; i < NUM_FLAGS; i++) begin
        if (evtVec[i]) begin
          flagVec[i] <= 1'b1;
        end else if (strobe.clrStatus) begin
          flagVec[i] <= 1'b0;
        end
      end
    end
  end

  assign irqOut = |(flagVec & ienVec);

  always_comb begin
    modeRead                = '0;
    modeRead[DIV_W-1:0]     = modeDiv;
    modeRead[BIT_ALM_IEN]   = almIen;
    modeRead[BIT_INC_IEN]   = incIen;
    statusRead              = '0;
    statusRead[NUM_FLAGS-1:0] = flagVec;
  end

  always_comb begin
    unique case (regSel)
      SEL_MODE:   busRdData = modeRead;
      SEL_ALARM:  busRdData = alarmVal;
      SEL_VALUE:  busRdData = valueCnt;
      default:    busRdData = statusRead;
    endcase
  end

endmodule

// File: rtl/rt_tick_timer.sv
module rt_tick_timer
  import rt_tick_timer_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int RESET_DIV = 32768,
  parameter int FULL_DIV  = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);

  ctlStrobe_t           strobe;
  cntEvent_t            evt;
  logic [PRE_W-1:0]     modeDiv;
  logic [DATA_W-1:0]    alarmVal;
  logic [DATA_W-1:0]    valueCnt;
  logic [NUM_FLAGS-1:0] flagVec;

  rt_tick_ctrl #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (DATA_W),
    .DIV_W    (PRE_W),
    .RESET_DIV(RESET_DIV)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdEn  (busRdEn),
    .busRdData(busRdData),
    .irqOut   (irqOut),
    .evt      (evt),
    .valueCnt (valueCnt),
    .strobe   (strobe),
    .modeDiv  (modeDiv),
    .alarmVal (alarmVal),
    .flagVec  (flagVec)
  );

  rt_tick_datapath #(
    .CNT_W   (DATA_W),
    .DIV_W   (PRE_W),
    .FULL_DIV(FULL_DIV)
  ) dpath (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .strobe  (strobe),
    .modeDiv (modeDiv),
    .alarmVal(alarmVal),
    .valueCnt(valueCnt),
    .evt     (evt)
  );

endmodule

// File: rtl/rt_tick_timer_chk.sv
module rt_tick_timer_chk
  import rt_tick_timer_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 refTick,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [DATA_W-1:0]    busWrData,
  input logic                 busRdEn,
  input logic                 irqOut,
  input logic [DATA_W-1:0]    valueCnt,
  input logic [DATA_W-1:0]    alarmVal,
  input logic [NUM_FLAGS-1:0] flagVec
);

  logic restartWr;
  logic statusRd;

  assign restartWr = busWrEn && (busAddr[3:2] == SEL_MODE) && busWrData[BIT_RESTART];
  assign statusRd  = busRdEn && (busAddr[3:2] == SEL_STATUS);

  // R3: the counter only moves by +1, and only on a reference pulse
  p_value_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(valueCnt) && !$past(restartWr)) |-> (valueCnt == $past(valueCnt) + DATA_W'(1)));

  p_step_needs_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(valueCnt) && !$past(restartWr)) |-> $past(refTick));

  // R5: restart write zeroes the counter
  p_restart_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    restartWr |=> (valueCnt == '0));

  // R6: a non-restart change of the counter leaves the increment flag set
  p_inc_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(valueCnt) && !$past(restartWr)) |-> flagVec[ST_INC]);

  // R7: no alarm while the alarm register is all ones
  p_alarm_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (alarmVal == '1) |=> !$rose(flagVec[ST_ALM]));

  // R9: a status read with no pulse pending drops the interrupt
  p_read_drops_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !refTick) |=> !irqOut);

  // R9: a flag only rises together with a counter step
  p_alarm_with_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagVec[ST_ALM]) |-> !$stable(valueCnt));

endmodule

bind rt_tick_timer rt_tick_timer_chk #(.ADDR_W(ADDR_W)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .refTick  (refTick),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdEn  (busRdEn),
  .irqOut   (irqOut),
  .valueCnt (valueCnt),
  .alarmVal (alarmVal),
  .flagVec  (flagVec)
);

// File: tb/rt_tick_timer_test.sv
module rt_tick_timer_test;

  localparam int ADDR_W = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  rt_tick_timer #(.ADDR_W(ADDR_W)) uut (
    .clk      (clk),
    .rstN     (rstN),
    .refTick  (refTick),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdEn  (busRdEn),
    .busRdData(busRdData),
    .irqOut   (irqOut)
  );

  // monitor: compares each read against the scoreboard
  always @(negedge clk) begin
    if (rstN && busRdEn) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %h expected none", busRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdData !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, busRdData, e);
        end
      end
    end
  end

  task automatic stepCycle();
    @(posedge clk);
    #1;
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    stepCycle();
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [11:0] a, input logic [31:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    busAddr = a; busRdEn = 1'b1;
    stepCycle();
    busRdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      refTick = 1'b1;
      stepCycle();
    end
    refTick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) stepCycle();
  endtask

  task automatic checkIrq(input logic e, input string t);
    checks++;
    if (irqOut !== e) begin
      errors++;
      $display("FAIL %s irq: actual %b expected %b", t, irqOut, e);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    stepCycle();

    // R1 reset state
    rdReg(12'h000, 32'h0000_8000, "R1 mode");
    rdReg(12'h004, 32'hFFFF_FFFF, "R1 alarm");
    rdReg(12'h008, 32'h0, "R1 value");
    rdReg(12'h00C, 32'h0, "R1 status");
    checkIrq(1'b0, "R1");

    // R3/R6 divide by 3, no interrupt enables
    wrReg(12'h000, 32'h0004_0003);
    ticks(2);
    rdReg(12'h008, 32'h0, "R3 before Nth pulse");
    ticks(1);
    checkIrq(1'b0, "R8 flag without enable");
    rdReg(12'h008, 32'h1, "R3 value");
    rdReg(12'h00C, 32'h2, "R6 inc flag");
    rdReg(12'h00C, 32'h0, "R9 cleared");

    // R8 increment interrupt
    wrReg(12'h000, 32'h0002_0003);
    ticks(3);
    checkIrq(1'b1, "R8 inc enable");
    rdReg(12'h00C, 32'h2, "R6 second step");
    checkIrq(1'b0, "R9 read drops irq");

    // R7 alarm fires one past the alarm value
    wrReg(12'h004, 32'h4);
    rdReg(12'h004, 32'h4, "R2 alarm rw");
    ticks(6);
    rdReg(12'h00C, 32'h2, "R7 no alarm at alarm value");
    ticks(3);
    wrReg(12'h000, 32'h0001_0003);
    checkIrq(1'b1, "R8 alarm enable");
    rdReg(12'h008, 32'h5, "R7 value");
    rdReg(12'h00C, 32'h3, "R7 alarm flag");
    checkIrq(1'b0, "R9 alarm irq dropped");
    ticks(3);
    checkIrq(1'b0, "R8 inc flag with only alarm enable");
    rdReg(12'h00C, 32'h2, "R7 alarm only once");

    // R9 event in the same cycle as a status read
    ticks(2);
    expQ.push_back(32'h0);
    tagQ.push_back("R9 read during event");
    busAddr = 12'h00C; busRdEn = 1'b1; refTick = 1'b1;
    stepCycle();
    busRdEn = 1'b0; refTick = 1'b0;
    rdReg(12'h00C, 32'h2, "R9 event wins");

    // R5 restart
    ticks(2);
    wrReg(12'h000, 32'h0004_0003);
    ticks(2);
    rdReg(12'h008, 32'h0, "R5 value cleared");
    ticks(1);
    rdReg(12'h008, 32'h1, "R5 prescaler restarted");
    rdReg(12'h000, 32'h3, "R5 bit18 reads 0");

    // R10 ignored writes
    wrReg(12'h008, 32'h55);
    wrReg(12'h00C, 32'h3);
    rdReg(12'h008, 32'h1, "R10 value write ignored");
    rdReg(12'h00C, 32'h2, "R10 status write ignored");
    rdReg(12'h00C, 32'h0, "R10 status clear");

    // R2 upper address bits ignored
    rdReg(12'h108, 32'h1, "R2 alias read");
    wrReg(12'h204, 32'h77);
    rdReg(12'h004, 32'h77, "R2 alias write");

    // R3 hold without reference pulses
    idle(10);
    rdReg(12'h008, 32'h1, "R3 hold");

    // R3 divide by 1
    wrReg(12'h000, 32'h0004_0001);
    ticks(5);
    rdReg(12'h008, 32'h5, "R3 divide by one");

    // R4 zero field means 32768
    wrReg(12'h000, 32'h0004_0000);
    rdReg(12'h000, 32'h0, "R4 mode zero");
    ticks(32767);
    rdReg(12'h008, 32'h0, "R4 before full period");
    ticks(1);
    rdReg(12'h008, 32'h1, "R4 full period");

    idle(2);
    if (expQ.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    finishRun();
  end

endmodule